// File: doc/BRIEF.md
# Status Flag Generator and Branch Condition Unit

This block sits beside a datapath's arithmetic unit. It takes two 8-bit operands and an operation code, forms the operation's result and four status bits from it: carry, sign, zero and overflow. When an operation is accepted, those bits are captured in a 4-bit status register. Subtraction is formed as the first operand plus the inverted second operand plus one. A carry of 1 after a subtraction therefore means that no borrow occurred.

A purely combinational decoder reads the captured status and a 4-bit condition code. It reports whether a branch on that condition is taken. The codes cover three kinds of test: tests of a single flag, unsigned magnitude relations, and signed magnitude relations. The magnitude relations are meant to be used after a compare. A compare and a test update the status like a subtract or an AND would, but they tell the surrounding datapath not to write their result back.

Operations enter on a valid/ready interface. The ready output is held high: the block never applies back-pressure, and every cycle with `op_valid` high at a rising clock edge counts as one accepted operation. The result and its write-back strobe follow the inputs combinationally. The status and the branch decision change only after the accepting edge.

Top module: `flagcond_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted operation, `status` is 4'b0000. Bit 3 of `status` is carry, bit 2 is sign, bit 1 is zero and bit 0 is overflow.
- R2: For add (`op_sel`=0), `result` is the low 8 bits of A+B. Carry is the carry out of bit 7. Overflow is set when the signed sum lies outside -128..+127.
- R3: For subtract (`op_sel`=1) and compare (`op_sel`=5), `result` is A-B modulo 256. Carry is 1 exactly when A >= B unsigned. Overflow is set when the signed difference lies outside -128..+127.
- R4: For every operation, zero is 1 exactly when `result` is 0, and sign equals `result` bit 7.
- R5: The logic operations clear carry and overflow. They are AND (`op_sel`=2), OR (3), XOR (4), test-AND (6) and pass-B (7), and their result is A&B, A|B, A^B, A&B and B respectively.
- R6: `status` loads the flags of the operation presented in a cycle with `op_valid` high, and becomes visible after that rising edge. With `op_valid` low it holds its value, whatever the operands and opcode do. `op_ready` is always 1.
- R7: `result_we` is 0 for compare and test-AND, and 1 for all other opcodes.
- R8: The single-flag conditions are evaluated on `status`: code 0 zero set, 1 zero clear, 2 carry set, 3 carry clear, 4 sign set, 5 sign clear, 6 overflow set, 7 overflow clear.
- R9: The unsigned conditions, after a compare of A and B, give the following results. Code 8 (C and not Z) is true when A > B, and code 9 when A <= B. Code 2 is true when A >= B, code 3 when A < B, code 0 when A == B and code 1 when A != B.
- R10: The signed conditions, after a compare, give the following results. Code 10 (S xor V clear) is true when A >= B, and code 11 when A < B. Code 12 (Z clear and S xor V clear) is true when A > B, and code 13 when A <= B.
- R11: Code 14 always reports taken, and code 15 never does.
- R12: `cond_true` depends only on `cond_sel` and the registered status. A new compare changes it only after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented |
| op_ready | output | 1 | Always 1; the block accepts every operation |
| op_sel | input | 3 | Operation code (see R2, R3, R5) |
| opnd_a | input | 8 | First operand A |
| opnd_b | input | 8 | Second operand B |
| result | output | 8 | Combinational operation result |
| result_we | output | 1 | Result should be written back |
| status | output | 4 | Registered flags {C, S, Z, V} |
| cond_sel | input | 4 | Branch condition code |
| cond_true | output | 1 | Selected condition holds |

## Verification
On every cycle, the embedded assertions check the following. Each add is compared with a wide-sum reference. Each subtract's carry must match the unsigned comparison of its operands, and its sign-xor-overflow must match the signed comparison. The status register must load on accepted operations and hold otherwise. Compares and tests must never raise the write-back strobe, and the always and never codes must be constant. Only the directed scenarios can show several things: the reset value, the one-cycle lag between an accepted compare and the new branch decision, and every one of the sixteen conditions against operand pairs chosen at the signed and unsigned boundaries (equal operands, 0x80 against 0x01, 0x7F against 0xFF).

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_CMP  = 3'd5,
    OP_TST  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  // Odd codes are the complement of the even code below them.
  typedef enum logic [3:0] {
    CC_ZS = 4'd0,  CC_ZC = 4'd1,
    CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_SS = 4'd4,  CC_SC = 4'd5,
    CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_UHI = 4'd8, CC_ULE = 4'd9,
    CC_SGE = 4'd10, CC_SLT = 4'd11,
    CC_SGT = 4'd12, CC_SLE = 4'd13,
    CC_ALW = 4'd14, CC_NEV = 4'd15
  } cond_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

endpackage

// File: rtl/flag_gen.sv
module flag_gen
  import flagcond_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output flags_t         flg,
  output logic           wb_en
);
  localparam int MSB = W - 1;

  logic         sub_mode;
  logic         arith;
  logic [W-1:0] b_eff;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic         carry_into_msb;

  // Adder shared by add, subtract and compare; subtract injects ~B and +1.
  always_comb begin
    sub_mode = (op == OP_SUB) || (op == OP_CMP);
    arith    = sub_mode || (op == OP_ADD);
    b_eff    = sub_mode ? ~b : b;
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_mode};
    low_sum  = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub_mode};
    carry_into_msb = low_sum[W-1];
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: res = full_sum[W-1:0];
      OP_AND, OP_TST:         res = a & b;
      OP_OR:                  res = a | b;
      OP_XOR:                 res = a ^ b;
      OP_PASS:                res = b;
      default:                res = '0;
    endcase
  end

  always_comb begin
    flg.c = arith & full_sum[W];
    flg.v = arith & (carry_into_msb ^ full_sum[W]);
    flg.s = res[MSB];
    flg.z = ~|res;
    wb_en = !((op == OP_CMP) || (op == OP_TST));
  end

  always_comb begin
    if (op == OP_ADD) begin
      assert_add_sum_R2: assert ({flg.c, res} == ({1'b0, a} + {1'b0, b}))
        else $error("add carry/result mismatch");
    end
    if (sub_mode) begin
      assert_sub_noborrow_R3: assert (flg.c == (a >= b))
        else $error("subtract carry is not the no-borrow bit");
      assert_sub_signed_R10: assert ((flg.s ^ flg.v) == ($signed(a) < $signed(b)))
        else $error("subtract S^V disagrees with signed less-than");
    end
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flagcond_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  assert_load_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)))
    else $error("status did not capture the accepted flags");

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q))
    else $error("status changed without an accepted operation");

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flagcond_pkg::*;
(
  input  flags_t      flg,
  input  logic [3:0]  code,
  output logic        taken
);
  localparam int NPAIR = 8;

  logic [NPAIR-1:0] base;
  logic             sgn_lt;

  // base[k] is the predicate of even code 2k; the odd code inverts it.
  always_comb begin
    sgn_lt  = flg.s ^ flg.v;
    base[0] = flg.z;
    base[1] = flg.c;
    base[2] = flg.s;
    base[3] = flg.v;
    base[4] = flg.c & ~flg.z;
    base[5] = ~sgn_lt;
    base[6] = ~flg.z & ~sgn_lt;
    base[7] = 1'b1;
    taken   = base[code[3:1]] ^ code[0];
  end

  always_comb begin
    if (code == CC_ALW) begin
      assert_always_taken_R11: assert (taken) else $error("always code not taken");
    end
    if (code == CC_NEV) begin
      assert_never_taken_R11: assert (!taken) else $error("never code taken");
    end
    if (code == CC_UHI && taken) begin
      assert_higher_needs_carry_R9: assert (flg.c && !flg.z)
        else $error("unsigned higher taken without carry");
    end
    if (code == CC_SGT && taken) begin
      assert_greater_needs_nonzero_R10: assert (!flg.z)
        else $error("signed greater taken on equal");
    end
  end

endmodule

// File: rtl/flagcond_top.sv
module flagcond_top
  import flagcond_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   status,
  input  logic [3:0]   cond_sel,
  output logic         cond_true
);
  flags_t next_flags;
  flags_t cur_flags;
  logic   accept;

  assign op_ready = 1'b1;
  assign accept   = op_valid & op_ready;

  flag_gen #(.W(W)) u_gen (
    .op    (alu_op_e'(op_sel)),
    .a     (opnd_a),
    .b     (opnd_b),
    .res   (result),
    .flg   (next_flags),
    .wb_en (result_we)
  );

  flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     (next_flags),
    .q     (cur_flags)
  );

  cond_eval u_cond (
    .flg   (cur_flags),
    .code  (cond_sel),
    .taken (cond_true)
  );

  assign status = cur_flags;

  assert_probe_no_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 3'd5) || (op_sel == 3'd6)) |-> !result_we)
    else $error("compare or test raised write-back");

endmodule

// File: tb/sim_flagcond_top.sv
module sim_flagcond_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic       op_ready;
  logic [2:0] op_sel;
  logic [7:0] opnd_a, opnd_b;
  logic [7:0] result;
  logic       result_we;
  logic [3:0] status;
  logic [3:0] cond_sel;
  logic       cond_true;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  flagcond_top u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .result_we(result_we), .status(status), .cond_sel(cond_sel),
    .cond_true(cond_true)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: returns {result, C, S, Z, V}
  function automatic logic [11:0] model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    int sa, sb, sr, ur;
    logic [7:0] r;
    logic c, v;
    sa = $signed(a); sb = $signed(b);
    c = 1'b0; v = 1'b0;
    case (op)
      3'd0: begin ur = int'(a) + int'(b); r = ur[7:0]; c = (ur > 255);
                  sr = sa + sb; v = (sr > 127) || (sr < -128); end
      3'd1, 3'd5: begin r = a - b; c = (a >= b);
                  sr = sa - sb; v = (sr > 127) || (sr < -128); end
      3'd2, 3'd6: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: r = b;
    endcase
    return {r, c, r[7], (r == 8'd0), v};
  endfunction

  task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [11:0] m;
    m = model(op, a, b);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; op_valid = 1'b1;
    #1;
    chk("R2/R3/R5 result", result, m[11:4]);
    chk("R7 result_we", result_we, (op == 3'd5 || op == 3'd6) ? 0 : 1);
    chk("R6 op_ready", op_ready, 1);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R2/R3/R4/R5 status", status, m[3:0]);
  endtask

  task automatic cond_is(input logic [3:0] code, input bit exp, input string tag);
    cond_sel = code;
    #1;
    chk(tag, cond_true, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 3'd0; opnd_a = 8'h00; opnd_b = 8'h00; cond_sel = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status, 0);
    cond_is(4'd14, 1, "R11 always");
    cond_is(4'd15, 0, "R11 never");
  endtask

  task automatic t_add();
    apply(3'd0, 8'hFF, 8'h01);   // carry, zero
    apply(3'd0, 8'h7F, 8'h01);   // signed overflow, sign
    apply(3'd0, 8'h80, 8'h80);   // carry, overflow, zero
    apply(3'd0, 8'h12, 8'h34);   // plain
  endtask

  task automatic t_sub();
    apply(3'd1, 8'h00, 8'h01);   // borrow
    apply(3'd1, 8'h80, 8'h01);   // overflow
    apply(3'd1, 8'h42, 8'h42);   // zero, no borrow
  endtask

  task automatic t_logic();
    apply(3'd1, 8'h00, 8'h01);   // leave C set-clear state nonzero
    apply(3'd2, 8'hF0, 8'h0F);
    apply(3'd3, 8'h80, 8'h01);
    apply(3'd4, 8'hAA, 8'hAA);
    apply(3'd7, 8'h00, 8'h90);
    apply(3'd6, 8'hC3, 8'h81);
  endtask

  task automatic t_flag_tests();
    logic [3:0] f;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a, b;
      logic [2:0] op;
      case (k)
        0: begin op = 3'd0; a = 8'hFF; b = 8'h01; end
        1: begin op = 3'd0; a = 8'h7F; b = 8'h01; end
        2: begin op = 3'd2; a = 8'h0F; b = 8'h0F; end
        default: begin op = 3'd1; a = 8'h80; b = 8'h01; end
      endcase
      apply(op, a, b);
      f = model(op, a, b) ~^ 12'h000 ? model(op, a, b) : 4'h0;
      cond_is(4'd0, f[1], "R8 zero set");
      cond_is(4'd1, !f[1], "R8 zero clear");
      cond_is(4'd2, f[3], "R8 carry set");
      cond_is(4'd3, !f[3], "R8 carry clear");
      cond_is(4'd4, f[2], "R8 sign set");
      cond_is(4'd5, !f[2], "R8 sign clear");
      cond_is(4'd6, f[0], "R8 overflow set");
      cond_is(4'd7, !f[0], "R8 overflow clear");
    end
  endtask

  task automatic t_compare(input logic [7:0] a, input logic [7:0] b);
    int sa, sb;
    sa = $signed(a); sb = $signed(b);
    apply(3'd5, a, b);
    cond_is(4'd0, a == b, "R9 equal");
    cond_is(4'd1, a != b, "R9 not equal");
    cond_is(4'd2, a >= b, "R9 unsigned higher-or-equal");
    cond_is(4'd3, a < b, "R9 unsigned lower");
    cond_is(4'd8, a > b, "R9 unsigned higher");
    cond_is(4'd9, a <= b, "R9 unsigned lower-or-equal");
    cond_is(4'd10, sa >= sb, "R10 signed greater-or-equal");
    cond_is(4'd11, sa < sb, "R10 signed less");
    cond_is(4'd12, sa > sb, "R10 signed greater");
    cond_is(4'd13, sa <= sb, "R10 signed less-or-equal");
    cond_is(4'd14, 1, "R11 always");
    cond_is(4'd15, 0, "R11 never");
  endtask

  task automatic t_hold_and_lag();
    logic [3:0] held;
    apply(3'd5, 8'h05, 8'h09);          // 5 < 9: lower
    held = status;
    cond_sel = 4'd3;
    @(negedge clk);
    op_valid = 1'b0; op_sel = 3'd0; opnd_a = 8'hFF; opnd_b = 8'h01;
    repeat (2) @(negedge clk);
    chk("R6 hold while idle", status, held);
    // new compare 9 vs 5: decision flips only after the accepting edge
    op_sel = 3'd5; opnd_a = 8'h09; opnd_b = 8'h05; op_valid = 1'b1;
    #1;
    chk("R12 lower before edge", cond_true, 1);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk("R12 lower after edge", cond_true, 0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_flag_tests();
    t_compare(8'h05, 8'h05);
    t_compare(8'hC8, 8'h03);
    t_compare(8'h03, 8'hC8);
    t_compare(8'h80, 8'h01);
    t_compare(8'h7F, 8'hFF);
    t_compare(8'h00, 8'h80);
    t_hold_and_lag();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule